// File: doc/BRIEF.md
# Decimal Adjust Unit

This unit repairs a byte pair after a plain binary add or subtract has been applied to decimal-coded digits. The low byte holds the digits being fixed, and the high byte takes a digit carry or borrow in the unpacked forms. Along with the two bytes, it takes the carry and half-carry flags left behind by the arithmetic step. A two-bit mode input selects one of four corrections:

- packed digits after an add;
- packed digits after a subtract;
- unpacked digits after an add;
- unpacked digits after a subtract.

The arithmetic that comes before the correction is outside the unit.

All correction logic is combinational and is decided from the input values alone. The corrected bytes and the five flags (carry, half-carry, zero, sign, parity) are captured in an output register. A result therefore appears one clock after its inputs. A new operation can be presented on every cycle.

Top module: `dec_adjust`

## Requirements
- R1: Mode 0 (packed, add): when the low nibble of the input low byte exceeds 9, or half-carry in is 1, the low byte gets +06h and half-carry out is 1. Otherwise this step adds nothing and half-carry out is 0.
- R2: Mode 0, second step: when the original low byte exceeds 9Fh, or carry in is 1, the byte also gets +60h and carry out is 1. Otherwise carry out is 0. Both tests use the input byte and flags, not the result of the first step, and the sum wraps modulo 256.
- R3: Mode 1 (packed, subtract) uses the same two tests and flag outputs as R1 and R2, but subtracts 06h and 60h, wrapping modulo 256. In both packed modes the high byte passes through unchanged.
- R4: Mode 2 (unpacked, add): when the low nibble exceeds 9, or half-carry in is 1, the low byte gets +6, the high byte gets +1 (wrapping), and both carry and half-carry out are 1. Otherwise both are 0 and the high byte is unchanged.
- R5: Mode 3 (unpacked, subtract) uses the same test as R4, but subtracts 6 from the low byte and 1 from the high byte, wrapping; the carry and half-carry outputs follow R4.
- R6: In modes 2 and 3, bits 7:4 of the output low byte are always 0.
- R7: In modes 0 and 1, the output flags describe the final low byte: zero is 1 when the byte is 00h, sign is bit 7, and parity is 1 when the byte has an even number of set bits.
- R8: In modes 2 and 3, the zero, sign and parity outputs are 0.
- R9: Outputs change only at a rising clock edge, and each one reflects the inputs sampled at that edge.
- R10: An active-low asynchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | 0 packed add, 1 packed subtract, 2 unpacked add, 3 unpacked subtract |
| al_in | input | 8 | Low byte to be corrected |
| ah_in | input | 8 | High byte |
| cf_in | input | 1 | Carry from the preceding arithmetic |
| af_in | input | 1 | Half-carry from the preceding arithmetic |
| al_out | output | 8 | Corrected low byte |
| ah_out | output | 8 | Corrected high byte |
| cf_out | output | 1 | Carry out |
| af_out | output | 1 | Half-carry out |
| zf_out | output | 1 | Zero flag |
| sf_out | output | 1 | Sign flag |
| pf_out | output | 1 | Parity flag (even) |

## Verification
In the packed modes, the nibble step and the high step can both fire on the same cycle. The bench provokes this directly in three ways:
- a low byte such as ABh, with no incoming flags;
- 00h with both flags set, in subtract mode;
- an exhaustive sweep of all 256 low bytes against every carry and half-carry combination.

Each result is judged against an independent model. That model takes both decisions from the original byte and flags, so it exposes any design that feeds the first step's result into the second test.

// File: rtl/dec_adjust.sv
module dec_adjust (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic [7:0] al_in,
  input  logic [7:0] ah_in,
  input  logic       cf_in,
  input  logic       af_in,
  output logic [7:0] al_out,
  output logic [7:0] ah_out,
  output logic       cf_out,
  output logic       af_out,
  output logic       zf_out,
  output logic       sf_out,
  output logic       pf_out
);
  localparam logic [3:0] NIB_MAX = 4'd9;
  localparam logic [7:0] BYTE_MAX = 8'h9F;
  localparam logic [7:0] LO_ADJ = 8'h06;
  localparam logic [7:0] HI_ADJ = 8'h60;

  logic       sub_op, unpacked, lo_fix, hi_fix;
  logic [7:0] lo_step, hi_step, pk_res, un_res, al_nx, ah_nx;
  logic [3:0] un_nib;

  assign sub_op   = mode[0];
  assign unpacked = mode[1];

  assign lo_fix  = (al_in[3:0] > NIB_MAX) | af_in;
  assign hi_fix  = (al_in > BYTE_MAX) | cf_in;
  assign lo_step = lo_fix ? LO_ADJ : 8'h00;
  assign hi_step = hi_fix ? HI_ADJ : 8'h00;

  assign pk_res = sub_op ? (al_in - lo_step - hi_step) : (al_in + lo_step + hi_step);
  assign un_nib = sub_op ? (al_in[3:0] - lo_step[3:0]) : (al_in[3:0] + lo_step[3:0]);
  assign un_res = {4'h0, un_nib};

  assign al_nx = unpacked ? un_res : pk_res;

  always_comb begin
    ah_nx = ah_in;
    if (unpacked && lo_fix)
      ah_nx = sub_op ? ah_in - 8'd1 : ah_in + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      al_out <= '0;
      ah_out <= '0;
      cf_out <= 1'b0;
      af_out <= 1'b0;
      zf_out <= 1'b0;
      sf_out <= 1'b0;
      pf_out <= 1'b0;
    end else begin
      al_out <= al_nx;
      ah_out <= ah_nx;
      cf_out <= unpacked ? lo_fix : hi_fix;
      af_out <= lo_fix;
      zf_out <= !unpacked && (al_nx == 8'h00);
      sf_out <= !unpacked && al_nx[7];
      pf_out <= !unpacked && !(^al_nx);
    end
  end
endmodule

module dec_adjust_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic [7:0] al_in,
  input logic [7:0] ah_in,
  input logic       cf_in,
  input logic       af_in,
  input logic [7:0] al_out,
  input logic [7:0] ah_out,
  input logic       cf_out,
  input logic       af_out,
  input logic       zf_out,
  input logic       sf_out,
  input logic       pf_out
);
  logic primed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;

  a_r1_aux_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !$past(mode[1]) && $past(af_in) |-> af_out);
  a_r2_hi_stage: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !$past(mode[1]) && ($past(al_in) > 8'h9F || $past(cf_in)) |-> cf_out);
  a_r3_high_byte_kept: assert property (@(posedge clk) disable iff (!rst_n)
    primed && !$past(mode[1]) |-> ah_out == $past(ah_in));
  a_r4_high_inc: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(mode) == 2'd2 |-> ah_out == $past(ah_in) + {7'd0, cf_out});
  a_r5_high_dec: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(mode) == 2'd3 |-> ah_out == $past(ah_in) - {7'd0, cf_out});
  a_r5_flags_pair: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(mode[1]) |-> cf_out == af_out);
  a_r6_high_nibble_clear: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(mode[1]) |-> al_out[7:4] == 4'h0);
  a_r8_flags_zero: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(mode[1]) |-> !zf_out && !sf_out && !pf_out);
endmodule

bind dec_adjust dec_adjust_chk chk_i (.*);

// File: tb/dec_adjust_tb_top.sv
`timescale 1ns/1ps
module dec_adjust_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = '0;
  logic [7:0] al_in = '0, ah_in = '0;
  logic       cf_in = 1'b0, af_in = 1'b0;
  logic [7:0] al_out, ah_out;
  logic       cf_out, af_out, zf_out, sf_out, pf_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dec_adjust dut_i (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [20:0] model(input int md, input int a, input int h,
                                        input int c, input int f);
    int r, rh, oc, oa, ones;
    bit z, s, p;
    r = a; rh = h; oc = 0; oa = 0; z = 0; s = 0; p = 0;
    if (md >= 2) begin
      if ((a % 16) > 9 || f != 0) begin
        r  = (md == 3) ? a - 6 : a + 6;
        rh = (md == 3) ? h - 1 : h + 1;
        oc = 1; oa = 1;
      end
      r = r & 15; rh = rh & 255;
    end else begin
      if ((a % 16) > 9 || f != 0) begin
        r = (md == 1) ? r - 6 : r + 6; oa = 1;
      end
      if (a > 159 || c != 0) begin
        r = (md == 1) ? r - 96 : r + 96; oc = 1;
      end
      r = r & 255;
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (r >> i) & 1;
      z = (r == 0); s = (r >= 128); p = (ones % 2 == 0);
    end
    return {r[7:0], rh[7:0], oc[0], oa[0], z, s, p};
  endfunction

  task automatic run_vec(input int md, input int a, input int h, input int c, input int f,
                         input string tag_data, input string tag_flags);
    logic [20:0] e;
    @(negedge clk);
    mode = md[1:0]; al_in = a[7:0]; ah_in = h[7:0]; cf_in = c[0]; af_in = f[0];
    @(negedge clk);
    e = model(md, a, h, c, f);
    chk(al_out == e[20:13], tag_data, al_out, e[20:13]);
    chk(ah_out == e[12:5], tag_data, ah_out, e[12:5]);
    chk({cf_out, af_out} == e[4:3], tag_data, {cf_out, af_out}, e[4:3]);
    chk({zf_out, sf_out, pf_out} == e[2:0], tag_flags, {zf_out, sf_out, pf_out}, e[2:0]);
  endtask

  task automatic test_reset();
    chk({al_out, ah_out, cf_out, af_out, zf_out, sf_out, pf_out} == '0, "R10 at start",
        {al_out, ah_out}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic test_packed_add();
    for (int a = 0; a < 256; a++)
      for (int fl = 0; fl < 4; fl++)
        run_vec(0, a, 8'h3C, fl >> 1, fl & 1, "R1 R2 packed add", "R7 packed add");
  endtask

  task automatic test_packed_sub();
    for (int a = 0; a < 256; a++)
      for (int fl = 0; fl < 4; fl++)
        run_vec(1, a, 8'hC3, fl >> 1, fl & 1, "R3 packed sub", "R7 packed sub");
  endtask

  task automatic test_unpacked_add();
    for (int a = 0; a < 256; a++)
      for (int fl = 0; fl < 4; fl++)
        run_vec(2, a, (a * 7 + 3) & 255, fl >> 1, fl & 1, "R4 R6 unpacked add", "R8 unpacked add");
  endtask

  task automatic test_unpacked_sub();
    for (int a = 0; a < 256; a++)
      for (int fl = 0; fl < 4; fl++)
        run_vec(3, a, (a * 5 + 1) & 255, fl >> 1, fl & 1, "R5 R6 unpacked sub", "R8 unpacked sub");
  endtask

  task automatic test_corners();
    run_vec(0, 8'hAB, 0, 0, 0, "R2 both steps same cycle", "R7 both steps");
    run_vec(0, 8'h9A, 0, 0, 0, "R2 original byte tested", "R7 original byte");
    run_vec(1, 8'h00, 0, 1, 1, "R3 both steps wrap", "R7 both steps sub");
    run_vec(0, 8'h00, 0, 0, 0, "R7 zero result", "R7 zero flag");
    run_vec(2, 8'h0F, 8'hFF, 0, 0, "R4 high byte wraps up", "R8 wrap up");
    run_vec(3, 8'h00, 8'h00, 0, 1, "R5 high byte wraps down", "R8 wrap down");
    run_vec(2, 8'hF9, 8'h10, 1, 0, "R6 no fix clears high nibble", "R8 no fix");
  endtask

  task automatic test_latency();
    run_vec(0, 8'h12, 0, 0, 0, "R9 setup", "R9 setup flags");
    @(negedge clk);
    mode = 2'd0; al_in = 8'h45; cf_in = 1'b0; af_in = 1'b0;
    #1;
    chk(al_out == 8'h12, "R9 holds before edge", al_out, 8'h12);
    @(negedge clk);
    chk(al_out == 8'h45, "R9 updates after edge", al_out, 8'h45);
  endtask

  task automatic test_mid_reset();
    run_vec(0, 8'hFF, 8'h77, 1, 1, "R10 setup", "R10 setup flags");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({al_out, ah_out, cf_out, af_out, zf_out, sf_out, pf_out} == '0, "R10 mid-run",
        {al_out, ah_out}, 0);
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #2;
    test_reset();
    test_latency();
    test_corners();
    test_packed_add();
    test_packed_sub();
    test_unpacked_add();
    test_unpacked_sub();
    test_mid_reset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule